// File: doc/BRIEF.md
# Interrupt Acknowledge Bus Sequencer

This block lives in a processor's bus interface unit. When a maskable interrupt request is seen while the core has interrupts enabled, it takes the external bus and runs two acknowledge bus cycles on a bus with 24 address bits and 16 data bits. The first cycle only signals the interrupt controller. The second cycle returns the 8-bit interrupt number on the low data byte. The sequencer hands that number to the core with a one-clock valid strobe.

Each acknowledge cycle has an address phase, marked by the start strobe, and then a data phase. The data phase repeats as wait states until the ready input is seen low. The two cycles differ only in address bit 2. A fixed run of idle states separates them, so that slow interrupt controllers have time to recover. The lock output stays asserted for the whole sequence. The block never drives the data bus, and it ignores any request to pipeline the next address.

Top module: `intack_seq`

## Requirements
- R1: A sequence starts only from idle, and only on a clock edge where `irq` and `int_en` are both high. `ads_n` and `lock_n` go low in the cycle after that edge. While `int_en` is low the outputs stay idle, whatever `irq` does.
- R2: The first acknowledge cycle drives byte address 4, so `addr[2]` is 1 and every other `addr` bit is 0. It also drives `ben_n` = 2'b10: the low byte lane is enabled and the high lane is disabled.
- R3: The second acknowledge cycle drives byte address 0, so `addr` is all zeros, with `ben_n` = 2'b10.
- R4: `bus_type` = {mem/io, data/control, write/read} reads 3'b000 (acknowledge) during both cycles and 3'b111 at all other times. `ads_n` is low for exactly one clock, the first clock of each cycle.
- R5: The data phase of each cycle repeats while `rdy_n` is high and ends on the edge where `rdy_n` is low. `rdy_n` has no effect during the address phase or during the idle gap.
- R6: `lock_n` goes low in the first clock of the first cycle. It stays low without a break until the second cycle completes, and it is high in the following clock.
- R7: Exactly GAP_CYC (default 4) clocks separate the two cycles. During them `ads_n` is high, `ben_n` is 2'b11, `bus_type` is 3'b111 and `lock_n` stays low.
- R8: `data_oe` is 0 at all times, so the block never drives the data bus.
- R9: Data present when the first cycle completes is discarded, and `vec` keeps its previous value. When the second cycle completes, `data_in[7:0]` is latched into `vec`.
- R10: `vec_valid` is high for exactly one clock, the clock after the second cycle completes. In that same clock `lock_n` is high and `busy` is 0.
- R11: `nxt_n` (the address pipelining request) has no effect on any output.
- R12: A synchronous reset on `rst` aborts any sequence. In the next clock the outputs are idle (`ads_n`, `lock_n` high, `busy` 0, `vec_valid` 0) and `vec` is 0.
- R13: `irq` and `int_en` are ignored while a sequence is in progress. The sequence runs to its end unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq | input | 1 | Maskable interrupt request |
| int_en | input | 1 | Core interrupt enable flag |
| rdy_n | input | 1 | Bus ready, active low |
| nxt_n | input | 1 | Address pipelining request, active low (ignored) |
| data_in | input | DATA_W (16) | External data bus |
| addr | output | ADDR_W-1 (23) | Word address bits [23:1] |
| ben_n | output | DATA_W/8 (2) | Byte lane enables, active low, bit 0 = low lane |
| ads_n | output | 1 | Address strobe, active low |
| lock_n | output | 1 | Bus lock, active low |
| bus_type | output | 3 | Cycle type code {mem/io, data/control, write/read} |
| data_oe | output | 1 | Data bus output enable (always 0) |
| busy | output | 1 | Sequence in progress |
| vec | output | VEC_W (8) | Captured interrupt number |
| vec_valid | output | 1 | One-clock strobe for a new `vec` |

## Verification
The embedded properties check, on every clock, the behaviours that are visible at the ports over time:
- the single-clock strobe and its address in each cycle;
- that a cycle can only start after an enabled request;
- the unbroken lock span and its release together with the valid strobe;
- the exact gap length, measured by an independent counter;
- that the vector holds its value between strobes.

Only the bench scenarios can show the rest:
- that wait-state counts track `rdy_n`, and that ready in the address phase or the gap is ignored;
- that first-cycle data is dropped and the value on the low byte is captured;
- that a reset in mid-sequence aborts cleanly;
- that toggling the pipelining request, the enable or the request changes nothing once the sequence has begun.

// File: rtl/intack_pkg.sv
package intack_pkg;

   typedef enum logic [2:0] {
      S_IDLE  = 3'd0,
      S_A1_T1 = 3'd1,
      S_A1_T2 = 3'd2,
      S_GAP   = 3'd3,
      S_A2_T1 = 3'd4,
      S_A2_T2 = 3'd5
   } ack_state_e;

   localparam logic [2:0] BT_ACK  = 3'b000;
   localparam logic [2:0] BT_NONE = 3'b111;

endpackage

// File: rtl/intack_fsm.sv
module intack_fsm
   import intack_pkg::*;
#(
   parameter int GAP_CYC = 4
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       irq,
   input  logic       int_en,
   input  logic       rdy_n,
   output ack_state_e st,
   output logic       cap
);

   localparam int GW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
   localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYC - 1);

   ack_state_e st_nx;
   logic [GW-1:0] gcnt;

   always_comb begin
      st_nx = st;
      unique case (st)
         S_IDLE:  if (irq && int_en) st_nx = S_A1_T1;
         S_A1_T1: st_nx = S_A1_T2;
         S_A1_T2: if (!rdy_n) st_nx = S_GAP;
         S_GAP:   if (gcnt == GAP_LAST) st_nx = S_A2_T1;
         S_A2_T1: st_nx = S_A2_T2;
         S_A2_T2: if (!rdy_n) st_nx = S_IDLE;
         default: st_nx = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st   <= S_IDLE;
         gcnt <= '0;
      end else begin
         st   <= st_nx;
         gcnt <= (st == S_GAP) ? gcnt + GW'(1) : '0;
      end
   end

   assign cap = (st == S_A2_T2) && !rdy_n;

   // R4: an address phase always hands over to a data phase
   p_t1_to_t2_r4 : assert property (@(posedge clk) disable iff (rst)
      (st == S_A1_T1 || st == S_A2_T1) |=> (st == S_A1_T2 || st == S_A2_T2));

   // R5: a data phase with ready high repeats
   p_wait_hold_r5 : assert property (@(posedge clk) disable iff (rst)
      ((st == S_A1_T2 || st == S_A2_T2) && rdy_n) |=> $stable(st));

endmodule

// File: rtl/intack_busdrv.sv
module intack_busdrv
   import intack_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter int DATA_W     = 16,
   parameter int ACK1_BADDR = 4,
   parameter int ACK2_BADDR = 0
) (
   input  ack_state_e            st,
   output logic [ADDR_W-1:1]     addr,
   output logic [DATA_W/8-1:0]   ben_n,
   output logic                  ads_n,
   output logic                  lock_n,
   output logic [2:0]            bus_type,
   output logic                  data_oe,
   output logic                  busy
);

   localparam int LANES = DATA_W / 8;
   localparam logic [ADDR_W-1:1] W1 = (ADDR_W-1)'(ACK1_BADDR >> 1);
   localparam logic [ADDR_W-1:1] W2 = (ADDR_W-1)'(ACK2_BADDR >> 1);

   logic in_a1, in_a2, active;

   assign in_a1  = (st == S_A1_T1) || (st == S_A1_T2);
   assign in_a2  = (st == S_A2_T1) || (st == S_A2_T2);
   assign active = in_a1 || in_a2;

   assign ads_n    = !((st == S_A1_T1) || (st == S_A2_T1));
   assign lock_n   = (st == S_IDLE);
   assign busy     = (st != S_IDLE);
   assign bus_type = active ? BT_ACK : BT_NONE;
   assign data_oe  = 1'b0;

   always_comb begin
      addr = '0;
      if (in_a1)      addr = W1;
      else if (in_a2) addr = W2;
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      if (g == 0) begin : g_low
         assign ben_n[g] = !active;
      end else begin : g_high
         assign ben_n[g] = 1'b1;
      end
   end

endmodule

// File: rtl/intack_vecreg.sv
module intack_vecreg #(
   parameter int DATA_W = 16,
   parameter int VEC_W  = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cap,
   input  logic [DATA_W-1:0] data_in,
   output logic [VEC_W-1:0]  vec,
   output logic              vec_valid
);

   logic [VEC_W-1:0] lane;

   if (VEC_W == DATA_W) begin : g_full
      assign lane = data_in;
   end else begin : g_slice
      logic unused_hi;
      assign lane      = data_in[VEC_W-1:0];
      assign unused_hi = ^data_in[DATA_W-1:VEC_W];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         vec       <= '0;
         vec_valid <= 1'b0;
      end else begin
         vec_valid <= cap;
         if (cap) vec <= lane;
      end
   end

   // R10: strobe lasts one clock
   p_valid_pulse_r10 : assert property (@(posedge clk) disable iff (rst)
      vec_valid |=> !vec_valid);

   // R9: the vector only moves with the strobe
   p_vec_hold_r9 : assert property (@(posedge clk) disable iff (rst)
      (!vec_valid && !$past(rst)) |-> $stable(vec));

endmodule

// File: rtl/intack_seq.sv
module intack_seq
   import intack_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter int DATA_W     = 16,
   parameter int VEC_W      = 8,
   parameter int GAP_CYC    = 4,
   parameter int ACK1_BADDR = 4,
   parameter int ACK2_BADDR = 0
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                irq,
   input  logic                int_en,
   input  logic                rdy_n,
   input  logic                nxt_n,
   input  logic [DATA_W-1:0]   data_in,
   output logic [ADDR_W-1:1]   addr,
   output logic [DATA_W/8-1:0] ben_n,
   output logic                ads_n,
   output logic                lock_n,
   output logic [2:0]          bus_type,
   output logic                data_oe,
   output logic                busy,
   output logic [VEC_W-1:0]    vec,
   output logic                vec_valid
);

   localparam int LANES = DATA_W / 8;
   localparam int CW    = $clog2(GAP_CYC + 2);
   localparam logic [ADDR_W-1:1] W1 = (ADDR_W-1)'(ACK1_BADDR >> 1);
   localparam logic [ADDR_W-1:1] W2 = (ADDR_W-1)'(ACK2_BADDR >> 1);

   if (DATA_W < 16 || (DATA_W % 8) != 0) begin : g_bad_data
      $error("DATA_W must be a multiple of 8, at least 16");
   end
   if (VEC_W < 1 || VEC_W > DATA_W) begin : g_bad_vec
      $error("VEC_W must lie in 1..DATA_W");
   end
   if (GAP_CYC < 1) begin : g_bad_gap
      $error("GAP_CYC must be at least 1");
   end
   if (ADDR_W < 4 || (ACK1_BADDR % 2) != 0 || (ACK2_BADDR % 2) != 0
       || ACK1_BADDR == ACK2_BADDR) begin : g_bad_addr
      $error("acknowledge addresses must be even, distinct and fit ADDR_W");
   end

   ack_state_e st;
   logic       cap;
   logic       unused_pipe;

   assign unused_pipe = nxt_n;

   intack_fsm #(.GAP_CYC(GAP_CYC)) u_fsm (
      .clk    (clk),
      .rst    (rst),
      .irq    (irq),
      .int_en (int_en),
      .rdy_n  (rdy_n),
      .st     (st),
      .cap    (cap)
   );

   intack_busdrv #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .ACK1_BADDR (ACK1_BADDR),
      .ACK2_BADDR (ACK2_BADDR)
   ) u_drv (
      .st       (st),
      .addr     (addr),
      .ben_n    (ben_n),
      .ads_n    (ads_n),
      .lock_n   (lock_n),
      .bus_type (bus_type),
      .data_oe  (data_oe),
      .busy     (busy)
   );

   intack_vecreg #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_vec (
      .clk       (clk),
      .rst       (rst),
      .cap       (cap),
      .data_in   (data_in),
      .vec       (vec),
      .vec_valid (vec_valid)
   );

   // independent gap measurement at the ports
   logic [CW-1:0] chk_gap;
   always_ff @(posedge clk) begin
      if (rst) chk_gap <= '0;
      else if (!lock_n && ads_n && (&ben_n) && chk_gap != {CW{1'b1}})
         chk_gap <= chk_gap + CW'(1);
      else chk_gap <= '0;
   end

   p_start_r1 : assert property (@(posedge clk) disable iff (rst)
      (!ads_n && $past(lock_n)) |-> $past(irq && int_en));

   p_first_addr_r2 : assert property (@(posedge clk) disable iff (rst)
      (!ads_n && $past(lock_n)) |-> (addr == W1 && ben_n[0] == 1'b0));

   p_second_addr_r3 : assert property (@(posedge clk) disable iff (rst)
      (!ads_n && $past(!lock_n)) |-> (addr == W2 && ben_n[0] == 1'b0));

   p_ads_pulse_r4 : assert property (@(posedge clk) disable iff (rst)
      !ads_n |=> ads_n);

   p_lock_hold_r6 : assert property (@(posedge clk) disable iff (rst)
      !lock_n |=> (!lock_n || vec_valid));

   p_gap_len_r7 : assert property (@(posedge clk) disable iff (rst)
      (!ads_n && $past(!lock_n)) |-> chk_gap == CW'(GAP_CYC));

   p_vec_after_ready_r9 : assert property (@(posedge clk) disable iff (rst)
      vec_valid |-> ($past(!rdy_n) && $past(!lock_n)));

   p_release_r10 : assert property (@(posedge clk) disable iff (rst)
      vec_valid |-> (lock_n && !busy));

   p_lane_hi_off_r2 : assert property (@(posedge clk) disable iff (rst)
      ben_n[LANES-1] == 1'b1);

endmodule

// File: tb/intack_seq_bench.sv
module intack_seq_bench;

   logic        clk = 1'b0;
   logic        rst, irq, int_en, rdy_n, nxt_n;
   logic [15:0] data_in;
   logic [23:1] addr;
   logic [1:0]  ben_n;
   logic        ads_n, lock_n, data_oe, busy, vec_valid;
   logic [2:0]  bus_type;
   logic [7:0]  vec;

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;
   logic [7:0] last_vec = 8'h00;

   intack_seq u_intack_seq (
      .clk(clk), .rst(rst), .irq(irq), .int_en(int_en), .rdy_n(rdy_n),
      .nxt_n(nxt_n), .data_in(data_in), .addr(addr), .ben_n(ben_n),
      .ads_n(ads_n), .lock_n(lock_n), .bus_type(bus_type), .data_oe(data_oe),
      .busy(busy), .vec(vec), .vec_valid(vec_valid)
   );

   always #10 clk = ~clk;

   function automatic logic [22:0] exp_addr(input int which);
      return (which == 1) ? 23'(4 >> 1) : 23'(0);
   endfunction

   function automatic logic [7:0] exp_vec(input logic [15:0] d);
      return d[7:0];
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic chk_idle(input string req);
      chk({req, " ads_n"}, int'(ads_n), 1);
      chk({req, " lock_n"}, int'(lock_n), 1);
      chk({req, " busy"}, int'(busy), 0);
      chk({req, " bus_type"}, int'(bus_type), 7);
      chk({req, " ben_n"}, int'(ben_n), 3);
   endtask

   task automatic chk_phase(input string req, input int which, input bit t1);
      chk({req, " ads_n"}, int'(ads_n), t1 ? 0 : 1);
      chk({req, " lock_n"}, int'(lock_n), 0);
      chk({req, " addr"}, int'(addr), int'(exp_addr(which)));
      chk({req, " ben_n"}, int'(ben_n), 2);
      chk({req, " bus_type"}, int'(bus_type), 0);
      chk({req, " data_oe R8"}, int'(data_oe), 0);
   endtask

   task automatic run_seq(input int w1, input int w2, input logic [15:0] d1,
                          input logic [15:0] d2, input bit hold_irq);
      irq = 1'b1; int_en = 1'b1; rdy_n = 1'b0;
      @(negedge clk);
      chk_phase("R1 R2 R4 first T1", 1, 1'b1);
      if (!hold_irq) irq = 1'b0;
      rdy_n = 1'b0;  // ready in the address phase must be ignored (R5)
      nxt_n = 1'($urandom);
      @(negedge clk);
      chk_phase("R5 R2 first T2", 1, 1'b0);
      for (int i = 0; i < w1; i++) begin
         rdy_n = 1'b1; nxt_n = 1'($urandom); data_in = 16'($urandom);
         @(negedge clk);
         chk_phase("R5 first wait", 1, 1'b0);
      end
      rdy_n = 1'b0; data_in = d1;
      for (int g = 0; g < 4; g++) begin
         @(negedge clk);
         chk("R7 gap ads_n", int'(ads_n), 1);
         chk("R7 gap lock_n R6", int'(lock_n), 0);
         chk("R7 gap ben_n", int'(ben_n), 3);
         chk("R7 gap bus_type", int'(bus_type), 7);
         chk("R9 first data dropped", int'(vec), int'(last_vec));
         chk("R10 no strobe in gap", int'(vec_valid), 0);
         rdy_n = 1'($urandom); nxt_n = 1'($urandom);   // R5 R11
         int_en = 1'($urandom); data_in = 16'($urandom); // R13
      end
      @(negedge clk);
      chk_phase("R3 R7 R11 R13 second T1", 2, 1'b1);
      rdy_n = 1'b0;
      @(negedge clk);
      chk_phase("R3 R5 second T2", 2, 1'b0);
      for (int i = 0; i < w2; i++) begin
         rdy_n = 1'b1; nxt_n = 1'($urandom); data_in = 16'($urandom);
         @(negedge clk);
         chk_phase("R5 second wait", 2, 1'b0);
      end
      rdy_n = 1'b0; data_in = d2;
      @(negedge clk);
      last_vec = exp_vec(d2);
      chk("R10 strobe", int'(vec_valid), 1);
      chk("R9 vector", int'(vec), int'(last_vec));
      chk("R6 R10 lock released", int'(lock_n), 1);
      chk_idle("R10 back to idle");
      irq = 1'b0; rdy_n = 1'b1; data_in = 16'($urandom);
      @(negedge clk);
      chk("R10 strobe one clock", int'(vec_valid), 0);
      chk("R9 vector held", int'(vec), int'(last_vec));
      chk_idle("R1 no restart");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'h1c5e_0a7b);
      rst = 1'b1; irq = 1'b0; int_en = 1'b0; rdy_n = 1'b1; nxt_n = 1'b1;
      data_in = 16'h0000;
      repeat (3) @(negedge clk);
      chk_idle("R12 reset state");
      chk("R12 vec reset", int'(vec), 0);
      chk("R12 no strobe", int'(vec_valid), 0);
      rst = 1'b0;

      // R1: request without enable
      irq = 1'b1; int_en = 1'b0;
      for (int i = 0; i < 6; i++) begin
         nxt_n = 1'($urandom);
         @(negedge clk);
         chk_idle("R1 masked request");
      end
      irq = 1'b0; int_en = 1'b1;
      @(negedge clk);
      chk_idle("R1 enable without request");

      // directed corners
      run_seq(0, 0, 16'hA5FF, 16'h3C00, 1'b0);   // zero waits, vector 0
      run_seq(7, 5, 16'h1234, 16'hEEFF, 1'b1);   // long waits, vector 255, R13
      run_seq(0, 3, 16'h00AA, 16'h9981, 1'b0);

      // R12: reset during the gap
      irq = 1'b1; int_en = 1'b1; rdy_n = 1'b1;
      @(negedge clk);
      irq = 1'b0; rdy_n = 1'b0;
      @(negedge clk);
      @(negedge clk);  // first gap clock
      chk("R12 in gap before reset", int'(lock_n), 0);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      last_vec = 8'h00;
      chk_idle("R12 aborted");
      chk("R12 vec cleared", int'(vec), 0);
      repeat (6) begin
         @(negedge clk);
         chk_idle("R12 stays idle");
      end

      // constrained random sequences
      for (int n = 0; n < 40; n++) begin
         run_seq(int'($urandom % 6), int'($urandom % 6), 16'($urandom),
                 16'($urandom), 1'($urandom));
         repeat (int'($urandom % 3)) begin
            @(negedge clk);
            chk_idle("R1 idle between");
         end
      end

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule